// File: doc/BRIEF.md
# Interrupt Vector Ring Producer

This block takes interrupt events from on-chip sources and stores each one as a four-word, 16-byte vector in a circular buffer in host-visible memory. Events enter through a small valid/ready FIFO. A writer drains the FIFO and emits the four words on a plain memory write port in four back-to-back cycles. It then advances a byte-granular write pointer, masked to a power-of-two ring size. If writeback is enabled, it also stores the new write pointer at a separate memory address.

The host drains vectors and reports its progress by writing a read pointer. The block drives a level interrupt while unread vectors exist. A re-arm mode produces a fresh rising edge after each read-pointer update that leaves work outstanding. When a new vector catches up with the read pointer, the producer keeps writing and overwrites old entries. If detection is enabled, it sets a sticky overflow flag in bit 0 of the reported write pointer. A write-one-to-clear control bit clears that flag.

Top module: `ivr_producer`

## Requirements
- R1: After reset, `irq_o` is 0, `mem_we_o` is 0, `evt_ready_o` is 1, the write pointer reads 0, and the status register reads 2 (idle set, busy clear).
- R2: The register map uses word indices on `reg_addr_i`:
  - 0 is control. Bit 0 enables the ring, bit 1 enables the interrupt, bit 2 enables overflow detection, bit 3 enables writeback, bit 4 enables re-arm, and bits [12:8] hold log2 of the ring size in 32-bit words. Bit 31 is write-only overflow-clear and reads 0.
  - 1 is the ring base, holding address bits [39:8].
  - 2 is the writeback address bits [31:0].
  - 3 is the writeback address bits [39:32], in data bits [7:0].
  - 4 is the read pointer.
  - 5 is the write pointer.
  - 6 is status, with bit 0 busy and bit 1 idle.
  - Control, base and both writeback address registers read back what was written.
- R3: Each vector is written as four words in four consecutive cycles, at ring base plus the write pointer plus 0, 4, 8 and 12:
  - word 0 is {24'b0, source[7:0]};
  - word 1 is {4'b0, data[27:0]};
  - word 2 is {pasid[15:0], vm[7:0], ring[7:0]};
  - word 3 is 0.
- R4: After a vector, the write pointer advances by 16 bytes modulo the ring size. The next vector after the last slot is written at offset 0.
- R5: With detection on, a vector whose advanced pointer equals the read pointer is still written, and bit 0 of the write-pointer register becomes 1. The flag stays 1 across later vectors until control bit 31 is written as 1.
- R6: With detection off, the same wraparound leaves bit 0 of the write-pointer register at 0.
- R7: With writeback on, each vector is followed by one more memory write of the write-pointer register value to the 40-bit writeback address.
- R8: With the ring disabled, no memory writes occur. Events collect in the FIFO, and `evt_ready_o` falls once it holds FIFO_DEPTH events. Enabling the ring drains them in arrival order.
- R9: `irq_o` is 1 exactly when the ring and the interrupt are both enabled and the write pointer differs from the read pointer or the overflow flag is set.
- R10: With re-arm on, a read-pointer write that leaves work pending drives `irq_o` low for one cycle, after which it returns high. With re-arm off, `irq_o` stays high.
- R11: Disabling the ring and writing 0 to both pointers gives a write pointer of 0, status idle, and `irq_o` 0.
- R12: The busy status bit is 1 while the FIFO holds an event or a vector is being written, and 0 once all work is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | FIFO can accept an event |
| evt_src_i | input | 8 | Event source id |
| evt_data_i | input | 28 | Event source data |
| evt_ring_i | input | 8 | Event ring id |
| evt_vm_i | input | 8 | Event VM id |
| evt_pasid_i | input | 16 | Event process address space id |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 40 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| irq_o | output | 1 | Pending-vector interrupt |

## Verification
The hardest state to reach from the ports is the overflow, because the ring must wrap all the way round onto the host read pointer. The bench gets there by choosing the smallest practical ring of four vector slots and leaving the read pointer at 0. It then pushes four events, so the fourth lands in the last slot and sets the flag. A fifth event confirms that the overwrite continues at offset 0 with the flag still held.

FIFO back-pressure is brought about in a similar way. The ring is held disabled while the FIFO is filled, and is then enabled so that the stored events drain.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  typedef struct packed {
    logic [15:0] pasid;
    logic [7:0]  vm;
    logic [7:0]  ring;
    logic [27:0] data;
    logic [7:0]  src;
  } ivr_evt_t;

  localparam int EVT_W = $bits(ivr_evt_t);

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_VEC,
    WR_WB
  } wr_state_e;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_BASE  = 3'd1;
  localparam logic [2:0] REG_WB_LO = 3'd2;
  localparam logic [2:0] REG_WB_HI = 3'd3;
  localparam logic [2:0] REG_RPTR  = 3'd4;
  localparam logic [2:0] REG_WPTR  = 3'd5;
  localparam logic [2:0] REG_STAT  = 3'd6;

  localparam int VEC_BYTES = 16;

endpackage

// File: rtl/ivr_fifo.sv
module ivr_fifo #(
  parameter int W     = 68,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_MAX);
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= step(wr_q);
      if (do_pop)  rd_q <= step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int MAX_LOG2 = 14,
  parameter int PTR_W    = MAX_LOG2 + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             ring_en_o,
  output logic             det_en_o,
  output logic             wb_en_o,
  output logic [PTR_W-1:0] ptr_mask_o,
  output logic [31:0]      base_o,
  output logic [39:0]      wb_addr_o,
  output logic [PTR_W-1:0] rptr_m_o,
  output logic             ovf_clr_o,
  output logic             wptr_ld_o,
  output logic [PTR_W-1:0] wptr_ld_val_o,
  input  logic [PTR_W-1:0] wptr_i,
  input  logic             ovf_i,
  input  logic             busy_i,
  output logic             irq_o
);
  logic             ring_en_q, irq_en_q, det_en_q, wb_en_q, rearm_q;
  logic [4:0]       sz_q, sz_eff;
  logic [31:0]      base_q, wb_lo_q;
  logic [7:0]       wb_hi_q;
  logic [PTR_W-1:0] rptr_q;
  logic             rptr_wr_q;
  logic [5:0]       shamt;
  logic [PTR_W:0]   span;
  logic [PTR_W-1:0] wptr_m;
  logic [31:0]      wptr_word;
  logic             idle, pend, wr_ctrl, wr_rptr;

  assign wr_ctrl = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_rptr = reg_we_i && (reg_addr_i == REG_RPTR);

  always_comb begin
    if (sz_q > 5'(MAX_LOG2))  sz_eff = 5'(MAX_LOG2);
    else if (sz_q < 5'd2)     sz_eff = 5'd2;
    else                      sz_eff = sz_q;
    shamt      = 6'(sz_eff) + 6'd2;
    span       = {{PTR_W{1'b0}}, 1'b1} << shamt;
    ptr_mask_o = PTR_W'(span - 1'b1) & ~PTR_W'(VEC_BYTES - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
      det_en_q  <= 1'b0;
      wb_en_q   <= 1'b0;
      rearm_q   <= 1'b0;
      sz_q      <= 5'd2;
      base_q    <= '0;
      wb_lo_q   <= '0;
      wb_hi_q   <= '0;
      rptr_q    <= '0;
      rptr_wr_q <= 1'b0;
    end else begin
      rptr_wr_q <= wr_rptr;
      if (reg_we_i) begin
        case (reg_addr_i)
          REG_CTRL: begin
            ring_en_q <= reg_wdata_i[0];
            irq_en_q  <= reg_wdata_i[1];
            det_en_q  <= reg_wdata_i[2];
            wb_en_q   <= reg_wdata_i[3];
            rearm_q   <= reg_wdata_i[4];
            sz_q      <= reg_wdata_i[12:8];
          end
          REG_BASE:  base_q  <= reg_wdata_i;
          REG_WB_LO: wb_lo_q <= reg_wdata_i;
          REG_WB_HI: wb_hi_q <= reg_wdata_i[7:0];
          REG_RPTR:  rptr_q  <= reg_wdata_i[PTR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign ring_en_o     = ring_en_q;
  assign det_en_o      = det_en_q;
  assign wb_en_o       = wb_en_q;
  assign base_o        = base_q;
  assign wb_addr_o     = {wb_hi_q, wb_lo_q};
  assign rptr_m_o      = rptr_q & ptr_mask_o;
  assign ovf_clr_o     = wr_ctrl && reg_wdata_i[31];
  assign wptr_ld_o     = reg_we_i && (reg_addr_i == REG_WPTR);
  assign wptr_ld_val_o = reg_wdata_i[PTR_W-1:0] & ~PTR_W'(VEC_BYTES - 1);

  assign wptr_m    = wptr_i & ptr_mask_o;
  assign wptr_word = 32'(wptr_i) | 32'(ovf_i);
  assign idle      = (wptr_m == rptr_m_o) && !ovf_i;
  assign pend      = (wptr_m != rptr_m_o) || ovf_i;
  // re-arm: one low cycle after a host read-pointer update
  assign irq_o     = ring_en_q && irq_en_q && pend && !(rearm_q && rptr_wr_q);

  always_comb begin
    case (reg_addr_i)
      REG_CTRL:  reg_rdata_o = {19'b0, sz_q, 3'b0, rearm_q, wb_en_q, det_en_q, irq_en_q, ring_en_q};
      REG_BASE:  reg_rdata_o = base_q;
      REG_WB_LO: reg_rdata_o = wb_lo_q;
      REG_WB_HI: reg_rdata_o = {24'b0, wb_hi_q};
      REG_RPTR:  reg_rdata_o = 32'(rptr_q);
      REG_WPTR:  reg_rdata_o = wptr_word;
      REG_STAT:  reg_rdata_o = {30'b0, idle, busy_i};
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ring_en_q && irq_en_q));

  assert_rearm_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rearm_q && $past(wr_rptr) && !$past(wr_ctrl)) |-> !irq_o);

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ring_en_i,
  input  logic             det_en_i,
  input  logic             wb_en_i,
  input  logic [PTR_W-1:0] ptr_mask_i,
  input  logic [31:0]      base_i,
  input  logic [39:0]      wb_addr_i,
  input  logic [PTR_W-1:0] rptr_m_i,
  input  logic             ovf_clr_i,
  input  logic             wptr_ld_i,
  input  logic [PTR_W-1:0] wptr_ld_val_i,
  input  ivr_evt_t         head_i,
  input  logic             head_valid_i,
  output logic             pop_o,
  output logic             mem_we_o,
  output logic [39:0]      mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic             ovf_o,
  output logic             active_o
);
  wr_state_e        state_q;
  logic [1:0]       idx_q;
  logic [PTR_W-1:0] wptr_q, wptr_m, wptr_nxt;
  logic             ovf_q, ovf_set;
  logic [39:0]      vec_addr;
  logic [31:0]      vec_word;

  assign wptr_m   = wptr_q & ptr_mask_i;
  assign wptr_nxt = (wptr_q + PTR_W'(VEC_BYTES)) & ptr_mask_i;
  assign pop_o    = (state_q == WR_VEC) && (idx_q == 2'd3);
  // the oldest surviving entry is overwritten once the pointer lands on the reader
  assign ovf_set  = pop_o && det_en_i && (wptr_nxt == rptr_m_i);
  assign vec_addr = {base_i, 8'h00} + 40'(wptr_m) + 40'({idx_q, 2'b00});

  always_comb begin
    case (idx_q)
      2'd0:    vec_word = {24'b0, head_i.src};
      2'd1:    vec_word = {4'b0, head_i.data};
      2'd2:    vec_word = {head_i.pasid, head_i.vm, head_i.ring};
      default: vec_word = '0;
    endcase
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_addr_o  = vec_addr;
    mem_wdata_o = vec_word;
    case (state_q)
      WR_VEC: mem_we_o = 1'b1;
      WR_WB: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = wb_addr_i;
        mem_wdata_o = 32'(wptr_q) | 32'(ovf_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (head_valid_i && ring_en_i) begin
          state_q <= WR_VEC;
          idx_q   <= '0;
        end
        WR_VEC: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == 2'd3) state_q <= wb_en_i ? WR_WB : WR_IDLE;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wptr_ld_i)  wptr_q <= wptr_ld_val_i;
      else if (pop_o) wptr_q <= wptr_nxt;
      if (ovf_set)                     ovf_q <= 1'b1;
      else if (ovf_clr_i || wptr_ld_i) ovf_q <= 1'b0;
    end
  end

  assign wptr_o   = wptr_q;
  assign ovf_o    = ovf_q;
  assign active_o = (state_q != WR_IDLE);

  assert_burst_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WR_VEC && idx_q != 2'd3 && !wptr_ld_i) |=>
      (mem_we_o && mem_addr_o == $past(mem_addr_o) + 40'd4));

  assert_wptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pop_o) && !$past(wptr_ld_i)) |->
      (wptr_q == (($past(wptr_q) + PTR_W'(VEC_BYTES)) & $past(ptr_mask_i))));

  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovf_q) && !$past(ovf_clr_i) && !$past(wptr_ld_i)) |-> ovf_q);

  assert_no_write_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WR_IDLE && !ring_en_i) |=> !mem_we_o);

endmodule

// File: rtl/ivr_producer.sv
module ivr_producer
  import ivr_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int MAX_LOG2   = 14
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_valid_i,
  output logic        evt_ready_o,
  input  logic [7:0]  evt_src_i,
  input  logic [27:0] evt_data_i,
  input  logic [7:0]  evt_ring_i,
  input  logic [7:0]  evt_vm_i,
  input  logic [15:0] evt_pasid_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_we_o,
  output logic [39:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        irq_o
);
  localparam int PTR_W = MAX_LOG2 + 2;

  ivr_evt_t         evt_in, head;
  logic             fifo_full, head_valid, pop;
  logic             ring_en, det_en, wb_en, ovf_clr, wptr_ld, ovf, active;
  logic [PTR_W-1:0] ptr_mask, rptr_m, wptr_ld_val, wptr;
  logic [31:0]      base;
  logic [39:0]      wb_addr;

  assign evt_in = '{pasid: evt_pasid_i, vm: evt_vm_i, ring: evt_ring_i,
                    data: evt_data_i, src: evt_src_i};
  assign evt_ready_o = !fifo_full;

  ivr_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (evt_valid_i),
    .data_i  (evt_in),
    .full_o  (fifo_full),
    .pop_i   (pop),
    .data_o  (head),
    .valid_o (head_valid)
  );

  ivr_regs #(.MAX_LOG2(MAX_LOG2), .PTR_W(PTR_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reg_we_i      (reg_we_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .ring_en_o     (ring_en),
    .det_en_o      (det_en),
    .wb_en_o       (wb_en),
    .ptr_mask_o    (ptr_mask),
    .base_o        (base),
    .wb_addr_o     (wb_addr),
    .rptr_m_o      (rptr_m),
    .ovf_clr_o     (ovf_clr),
    .wptr_ld_o     (wptr_ld),
    .wptr_ld_val_o (wptr_ld_val),
    .wptr_i        (wptr),
    .ovf_i         (ovf),
    .busy_i        (head_valid || active),
    .irq_o         (irq_o)
  );

  ivr_writer #(.PTR_W(PTR_W)) u_writer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ring_en_i     (ring_en),
    .det_en_i      (det_en),
    .wb_en_i       (wb_en),
    .ptr_mask_i    (ptr_mask),
    .base_i        (base),
    .wb_addr_i     (wb_addr),
    .rptr_m_i      (rptr_m),
    .ovf_clr_i     (ovf_clr),
    .wptr_ld_i     (wptr_ld),
    .wptr_ld_val_i (wptr_ld_val),
    .head_i        (head),
    .head_valid_i  (head_valid),
    .pop_o         (pop),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_wdata_o   (mem_wdata_o),
    .wptr_o        (wptr),
    .ovf_o         (ovf),
    .active_o      (active)
  );

endmodule

// File: tb/ivr_producer_tb_top.sv
module ivr_producer_tb_top;
  localparam int DEPTH = 4;
  localparam logic [39:0] RBASE = 40'h00ABCD0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [7:0]  evt_src = '0;
  logic [27:0] evt_data = '0;
  logic [7:0]  evt_ring = '0;
  logic [7:0]  evt_vm = '0;
  logic [15:0] evt_pasid = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [39:0] log_addr [64];
  logic [31:0] log_data [64];
  int          log_cyc  [64];
  int          log_n = 0;

  always #5 clk = ~clk;

  ivr_producer #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_ready_o(evt_ready),
    .evt_src_i(evt_src), .evt_data_i(evt_data), .evt_ring_i(evt_ring),
    .evt_vm_i(evt_vm), .evt_pasid_i(evt_pasid),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_we && log_n < 64) begin
      log_addr[log_n] <= mem_addr;
      log_data[log_n] <= mem_wdata;
      log_cyc[log_n]  <= cyc;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_evt(input logic [7:0] s, input logic [27:0] d, input logic [7:0] r,
                          input logic [7:0] v, input logic [15:0] p);
    @(negedge clk);
    evt_src = s; evt_data = d; evt_ring = r; evt_vm = v; evt_pasid = p;
    evt_valid = 1'b1;
    for (int g = 0; g < 1000 && !evt_ready; g++) @(negedge clk);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int g = 0; g < 200; g++) begin
      reg_rd(3'd6, st);
      if (!st[0]) break;
    end
  endtask

  task automatic ptr_reset();
    reg_wr(3'd0, 32'h0000_0400);
    reg_wr(3'd4, 32'h0);
    reg_wr(3'd5, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", irq, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 ready", evt_ready, 1);
    reg_rd(3'd5, v); chk("R1 wptr", v, 0);
    reg_rd(3'd6, v); chk("R1 status", v, 2);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_wr(3'd1, 32'h00AB_CD00);
    reg_wr(3'd2, 32'h0000_2000);
    reg_wr(3'd3, 32'h0000_007F);
    reg_wr(3'd0, 32'h8000_0407);
    reg_rd(3'd1, v); chk("R2 base", v, 32'h00AB_CD00);
    reg_rd(3'd2, v); chk("R2 wb_lo", v, 32'h0000_2000);
    reg_rd(3'd3, v); chk("R2 wb_hi", v, 32'h7F);
    reg_rd(3'd0, v); chk("R2 ctrl", v, 32'h407);
  endtask

  task automatic t_vector();
    logic [31:0] v;
    log_n = 0;
    send_evt(8'h5A, 28'hFEDCBA9, 8'h11, 8'h22, 16'hBEEF);
    wait_idle();
    chk("R3 count", log_n, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 addr", log_addr[k], RBASE + 40'(4 * k));
      chk("R3 consecutive", log_cyc[k], log_cyc[0] + k);
    end
    chk("R3 word0", log_data[0], 32'h0000_005A);
    chk("R3 word1", log_data[1], 32'h0FED_CBA9);
    chk("R3 word2", log_data[2], 32'hBEEF_2211);
    chk("R3 word3", log_data[3], 32'h0);
    reg_rd(3'd5, v); chk("R4 wptr step", v, 32'h10);
    chk("R9 irq pending", irq, 1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    send_evt(8'h01, 28'h1, 8'h0, 8'h0, 16'h0);
    send_evt(8'h02, 28'h2, 8'h0, 8'h0, 16'h0);
    wait_idle();
    reg_rd(3'd5, v); chk("R5 no flag before full", v, 32'h30);
    log_n = 0;
    send_evt(8'h03, 28'h3, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R5 last slot addr", log_addr[0], RBASE + 40'h30);
    reg_rd(3'd5, v); chk("R5 flag set", v, 32'h1);
    chk("R9 irq on overflow", irq, 1);
    log_n = 0;
    send_evt(8'h04, 28'h4, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R4 wrap addr", log_addr[0], RBASE);
    chk("R5 overwrite data", log_data[0], 32'h04);
    reg_rd(3'd5, v); chk("R5 flag sticky", v, 32'h11);
    reg_wr(3'd0, 32'h8000_0407);
    reg_rd(3'd5, v); chk("R5 flag cleared", v, 32'h10);
  endtask

  task automatic t_ptr_reset();
    logic [31:0] v;
    ptr_reset();
    reg_rd(3'd5, v); chk("R11 wptr zero", v, 0);
    reg_rd(3'd6, v); chk("R11 idle", v, 2);
    chk("R11 irq low", irq, 0);
  endtask

  task automatic t_nodet();
    logic [31:0] v;
    reg_wr(3'd0, 32'h0000_0403);
    log_n = 0;
    for (int i = 0; i < 4; i++) send_evt(8'(i), 28'(i), 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R6 writes", log_n, 16);
    reg_rd(3'd5, v); chk("R6 no flag", v, 0);
    ptr_reset();
  endtask

  task automatic t_writeback();
    reg_wr(3'd0, 32'h0000_040F);
    log_n = 0;
    send_evt(8'h77, 28'h5, 8'h0, 8'h0, 16'h0);
    wait_idle();
    chk("R7 count", log_n, 5);
    chk("R7 addr", log_addr[4], 40'h7F_0000_2000);
    chk("R7 data", log_data[4], 32'h10);
    ptr_reset();
  endtask

  task automatic t_gate();
    logic [31:0] v;
    reg_wr(3'd0, 32'h0000_0602);
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) send_evt(8'(8'hC0 + i), 28'(i), 8'h0, 8'h0, 16'h0);
    repeat (4) @(negedge clk);
    chk("R8 no writes", log_n, 0);
    chk("R8 ready low", evt_ready, 0);
    reg_rd(3'd6, v); chk("R12 busy", v[0], 1);
    reg_wr(3'd0, 32'h0000_0603);
    wait_idle();
    chk("R8 drained", log_n, 16);
    chk("R8 order first", log_data[0], 32'hC0);
    chk("R8 order last", log_data[12], 32'hC3);
    reg_rd(3'd5, v); chk("R8 wptr", v, 32'h40);
    reg_rd(3'd6, v); chk("R12 not busy", v, 0);
  endtask

  task automatic t_rearm();
    reg_wr(3'd0, 32'h0000_0613);
    chk("R10 irq before", irq, 1);
    reg_wr(3'd4, 32'h20);
    #1 chk("R10 low gap", irq, 0);
    @(negedge clk); #1 chk("R10 raised again", irq, 1);
    reg_wr(3'd0, 32'h0000_0603);
    reg_wr(3'd4, 32'h30);
    #1 chk("R10 no gap without rearm", irq, 1);
    @(negedge clk); #1 chk("R10 still high", irq, 1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    reg_wr(3'd0, 32'h0000_0601);
    #1 chk("R9 irq disabled", irq, 0);
    reg_wr(3'd0, 32'h0000_0603);
    #1 chk("R9 irq enabled", irq, 1);
    reg_wr(3'd4, 32'h40);
    #1 chk("R9 irq drained", irq, 0);
    reg_rd(3'd6, v); chk("R11 idle after drain", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_vector();
    t_overflow();
    t_ptr_reset();
    t_nodet();
    t_writeback();
    t_gate();
    t_rearm();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule